// File: doc/BRIEF.md
# Load Address and Result Formatting Unit

This unit handles the load side of a 32-bit core. An operation arrives as a set of fields: addressing mode, access size, result format, lane or byte select, index shift, base pointer, index register, raw displacement, the old destination value and the condition outcome. From these the unit forms the effective address and, in auto-increment and auto-decrement modes, the updated pointer. It then issues one request on a valid/ready memory port. When the response arrives, it shapes the returned data into the value to write back. Shaping covers zero or sign extension, byte reversal, insertion into one lane of the old destination, or a 64-bit register-pair result.

Only one load is in flight at a time. `op_ready` is high only while the unit is idle, and a new operation is taken on a cycle where `op_valid` and `op_ready` are both high. Memory is big-endian: the byte at the lowest address of a word sits in bits 31:24. For accesses narrower than a doubleword, the response carries the aligned word that contains the address in `mem_rsp_data[31:0]`. For a doubleword, `mem_rsp_data[63:32]` holds the word at the address and `mem_rsp_data[31:0]` holds the word at address+4.

Top module: `load_unit`

## Requirements
- R1: After reset, `op_ready` is 1 and `mem_req_valid`, `wb_valid` and `ptr_wb_valid` are 0.
- R2: Mode 0 (post-increment) uses the base as the address, and mode 1 (pre-decrement) uses base minus the access size as the address. In both modes the new pointer is base plus or minus the access size (size code 0=1, 1=2, 2=4, 3=8 bytes). It appears on `ptr_wb_data`, with `ptr_wb_valid` high for exactly the cycle after acceptance. No other mode raises `ptr_wb_valid`.
- R3: Mode 2 (short) adds a zero-extended displacement to the base. For byte and halfword, the field is `op_disp[2:0]` scaled by the access size. For word and doubleword, the field is `op_disp[4:0]` scaled by 4.
- R4: Mode 3 (long) adds `op_disp` sign-extended from 16 bits, without scaling.
- R5: Mode 4 adds `op_index` shifted left by `op_shamt` (0..3). Mode 5 adds the index byte chosen by `op_lane` (lane 0 = bits 7:0), shifted left by 2.
- R6: Mode 6 (conditional) adds `op_disp[8:0]`, zero-extended and shifted by the size code. When `op_cond_ok` is 0, no memory request, no pointer update and no write-back occur, and `op_ready` stays 1.
- R7: Mode 7 clears bits 1:0 of the base and adds `op_disp[6:0]`, zero-extended, times 4.
- R8: Mode 8 adds `op_disp[11:0]`, sign-extended and shifted by the size code.
- R9: Format 0 zero-extends and format 1 sign-extends the byte or halfword at the address, taken big-endian from the response word. A word result is the response word unchanged.
- R10: Format 2 swaps the two halfword bytes and then sign-extends. Format 3 swaps them and then zero-extends. Format 4 reverses all four bytes of a word.
- R11: Format 5 writes the loaded byte into byte lane `op_lane`, or the halfword into halfword lane `op_lane[0]` (lane 0 = low bits), of `op_dest_old`. All other bits are kept.
- R12: Size 3 returns 64 bits on `wb_data`. The word at the address goes to `wb_data[63:32]`, the upper register of the pair, and the word at address+4 goes to `wb_data[31:0]`.
- R13: `mem_req_valid` rises the cycle after acceptance and holds with a stable address until `mem_req_ready`. `op_ready` stays low from acceptance until the result. `wb_valid` pulses for one cycle, the cycle after `mem_rsp_valid` is seen, and in that same cycle `op_ready` is 1. For sizes below doubleword, `wb_data[63:32]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation can be taken |
| op_mode | input | 4 | Addressing mode code 0..8 |
| op_size | input | 2 | Access size code |
| op_fmt | input | 3 | Result format code 0..5 |
| op_lane | input | 2 | Insert lane or index byte select |
| op_shamt | input | 2 | Index shift amount |
| op_base | input | 32 | Base pointer value |
| op_index | input | 32 | Index register value |
| op_disp | input | 16 | Raw displacement field |
| op_dest_old | input | 32 | Old destination value for inserts |
| op_cond_ok | input | 1 | Condition outcome for mode 6 |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_size | output | 2 | Request size code |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_data | input | 64 | Response data |
| wb_valid | output | 1 | Result valid pulse |
| wb_data | output | 64 | Formatted result |
| ptr_wb_valid | output | 1 | Pointer update valid pulse |
| ptr_wb_data | output | 32 | Updated pointer |

## Verification
Counting from the clock edge that accepts an operation, the address and the pointer update are both due one edge later. The result is due one edge after the edge that samples `mem_rsp_valid`, and a skipped conditional load must show nothing on the following cycle. The bench drives its inputs on falling edges and checks the reference model's expected values on the next falling edge after each such rising edge. While the memory withholds `mem_req_ready`, it also checks on every intermediate cycle that the request is held and that no pulse repeats.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int XLEN    = 32;
  localparam int DLEN    = 2 * XLEN;
  localparam int DISP_W  = 16;
  localparam int SHORT_N = 3;
  localparam int SHORT_W = 5;
  localparam int COND_W  = 9;
  localparam int PCSP_W  = 7;
  localparam int INS_W   = 12;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} size_e;

  typedef enum logic [3:0] {
    AM_POSTINC = 4'd0, AM_PREDEC = 4'd1, AM_SHORT = 4'd2, AM_LONG  = 4'd3,
    AM_INDEX   = 4'd4, AM_IDXBYT = 4'd5, AM_COND  = 4'd6, AM_PCSP  = 4'd7,
    AM_DISP12  = 4'd8
  } amode_e;

  typedef enum logic [2:0] {
    FX_ZERO = 3'd0, FX_SIGN = 3'd1, FX_SWAPS = 3'd2,
    FX_SWAPZ = 3'd3, FX_SWAPW = 3'd4, FX_INSERT = 3'd5
  } fmt_e;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WAIT = 2'd2} state_e;

  // keep the low w bits of v, clear the rest
  function automatic word_t zext(input word_t v, input int w);
    word_t mask;
    mask = (word_t'(1) << w) - word_t'(1);
    return v & mask;
  endfunction

  // replicate bit w-1 of v into the upper bits
  function automatic word_t sext(input word_t v, input int w);
    word_t t;
    t = v << (XLEN - w);
    return word_t'($signed(t) >>> (XLEN - w));
  endfunction

  function automatic word_t size_bytes(input size_e s);
    return word_t'(1) << s;
  endfunction

  function automatic logic [7:0] byte_of(input word_t w, input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction
endpackage

// File: rtl/ldu_addr.sv
module ldu_addr
  import ldu_pkg::*;
(
  input  amode_e          mode,
  input  size_e           size,
  input  logic [1:0]      shamt,
  input  logic [1:0]      lane,
  input  word_t           base,
  input  word_t           index,
  input  logic [DISP_W-1:0] disp,
  output word_t           ea,
  output word_t           ptr_new,
  output logic            ptr_upd
);
  word_t d;
  word_t step;

  always_comb begin
    d       = word_t'(disp);
    step    = size_bytes(size);
    ptr_new = base;
    ptr_upd = 1'b0;
    unique case (mode)
      AM_POSTINC: begin
        ea      = base;
        ptr_new = base + step;
        ptr_upd = 1'b1;
      end
      AM_PREDEC: begin
        ptr_new = base - step;
        ea      = ptr_new;
        ptr_upd = 1'b1;
      end
      AM_SHORT:  ea = (size == SZ_B || size == SZ_H)
                      ? base + (zext(d, SHORT_N) << size)
                      : base + (zext(d, SHORT_W) << 2);
      AM_LONG:   ea = base + sext(d, DISP_W);
      AM_INDEX:  ea = base + (index << shamt);
      AM_IDXBYT: ea = base + (word_t'(byte_of(index, lane)) << 2);
      AM_COND:   ea = base + (zext(d, COND_W) << size);
      AM_PCSP:   ea = {base[XLEN-1:2], 2'b00} + (zext(d, PCSP_W) << 2);
      AM_DISP12: ea = base + (sext(d, INS_W) << size);
      default:   ea = base;
    endcase
  end
endmodule

// File: rtl/ldu_fmt.sv
module ldu_fmt
  import ldu_pkg::*;
(
  input  size_e            size,
  input  fmt_e             fmt,
  input  logic [1:0]       lane,
  input  logic [1:0]       off,
  input  word_t            old_dest,
  input  logic [DLEN-1:0]  rsp,
  output logic [DLEN-1:0]  result
);
  word_t       w;
  word_t       r;
  logic [7:0]  b;
  logic [15:0] h;
  logic [15:0] hs;

  always_comb begin
    w  = rsp[XLEN-1:0];
    b  = byte_of(w, ~off);             // big-endian: offset 0 is the top byte
    h  = off[1] ? w[15:0] : w[31:16];
    hs = {h[7:0], h[15:8]};
    r  = '0;
    unique case (size)
      SZ_B: begin
        if (fmt == FX_SIGN)        r = sext(word_t'(b), 8);
        else if (fmt == FX_INSERT) begin
          r = old_dest;
          r[8*lane +: 8] = b;
        end
        else                       r = word_t'(b);
      end
      SZ_H: begin
        if (fmt == FX_SIGN)        r = sext(word_t'(h), 16);
        else if (fmt == FX_SWAPS)  r = sext(word_t'(hs), 16);
        else if (fmt == FX_SWAPZ)  r = word_t'(hs);
        else if (fmt == FX_INSERT) begin
          r = old_dest;
          r[16*lane[0] +: 16] = h;
        end
        else                       r = word_t'(h);
      end
      SZ_W: r = (fmt == FX_SWAPW) ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
      default: r = '0;
    endcase
    result = (size == SZ_D) ? rsp : {{XLEN{1'b0}}, r};
  end
endmodule

// File: rtl/load_unit.sv
module load_unit
  import ldu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [3:0]       op_mode,
  input  logic [1:0]       op_size,
  input  logic [2:0]       op_fmt,
  input  logic [1:0]       op_lane,
  input  logic [1:0]       op_shamt,
  input  logic [31:0]      op_base,
  input  logic [31:0]      op_index,
  input  logic [15:0]      op_disp,
  input  logic [31:0]      op_dest_old,
  input  logic             op_cond_ok,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [31:0]      mem_req_addr,
  output logic [1:0]       mem_req_size,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             wb_valid,
  output logic [63:0]      wb_data,
  output logic             ptr_wb_valid,
  output logic [31:0]      ptr_wb_data
);
  state_e     state;
  word_t      req_addr;
  size_e      req_size;
  fmt_e       req_fmt;
  logic [1:0] req_lane;
  word_t      req_old;

  word_t      a_ea;
  word_t      a_ptr;
  logic       a_upd;
  logic [DLEN-1:0] f_res;

  // named events used by the checker
  logic offer;
  logic skip_fire;
  logic issue_fire;
  logic auto_fire;
  logic rsp_take;

  ldu_addr u_addr (
    .mode    (amode_e'(op_mode)),
    .size    (size_e'(op_size)),
    .shamt   (op_shamt),
    .lane    (op_lane),
    .base    (op_base),
    .index   (op_index),
    .disp    (op_disp),
    .ea      (a_ea),
    .ptr_new (a_ptr),
    .ptr_upd (a_upd)
  );

  ldu_fmt u_fmt (
    .size     (req_size),
    .fmt      (req_fmt),
    .lane     (req_lane),
    .off      (req_addr[1:0]),
    .old_dest (req_old),
    .rsp      (mem_rsp_data),
    .result   (f_res)
  );

  assign op_ready      = (state == ST_IDLE);
  assign offer         = op_valid && op_ready;
  assign skip_fire     = offer && (amode_e'(op_mode) == AM_COND) && !op_cond_ok;
  assign issue_fire    = offer && !skip_fire;
  assign auto_fire     = issue_fire && a_upd;
  assign rsp_take      = (state == ST_WAIT) && mem_rsp_valid;
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = req_addr;
  assign mem_req_size  = req_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      req_addr     <= '0;
      req_size     <= SZ_B;
      req_fmt      <= FX_ZERO;
      req_lane     <= '0;
      req_old      <= '0;
      wb_valid     <= 1'b0;
      wb_data      <= '0;
      ptr_wb_valid <= 1'b0;
      ptr_wb_data  <= '0;
    end else begin
      wb_valid     <= 1'b0;
      ptr_wb_valid <= auto_fire;
      if (auto_fire) ptr_wb_data <= a_ptr;
      unique case (state)
        ST_IDLE: if (issue_fire) begin
          state    <= ST_REQ;
          req_addr <= a_ea;
          req_size <= size_e'(op_size);
          req_fmt  <= fmt_e'(op_fmt);
          req_lane <= op_lane;
          req_old  <= op_dest_old;
        end
        ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          wb_valid <= 1'b1;
          wb_data  <= f_res;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldu_checks.sv
module ldu_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        op_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        wb_valid,
  input logic        ptr_wb_valid,
  input logic        skip_fire,
  input logic        auto_fire,
  input logic        rsp_take
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R13
  AST_BUSY_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !op_ready); // R13
  AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> wb_valid && op_ready); // R13
  AST_WB_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(rsp_take)); // R13
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    skip_fire |=> !mem_req_valid && !ptr_wb_valid && op_ready); // R6
  AST_PTR_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wb_valid |-> $past(auto_fire)); // R2
endmodule

bind load_unit ldu_checks u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_ready      (op_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .wb_valid      (wb_valid),
  .ptr_wb_valid  (ptr_wb_valid),
  .skip_fire     (skip_fire),
  .auto_fire     (auto_fire),
  .rsp_take      (rsp_take)
);

// File: tb/test_load_unit.sv
module test_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [3:0]  op_mode = '0;
  logic [1:0]  op_size = '0;
  logic [2:0]  op_fmt = '0;
  logic [1:0]  op_lane = '0;
  logic [1:0]  op_shamt = '0;
  logic [31:0] op_base = '0;
  logic [31:0] op_index = '0;
  logic [15:0] op_disp = '0;
  logic [31:0] op_dest_old = '0;
  logic        op_cond_ok = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        wb_valid;
  logic [63:0] wb_data;
  logic        ptr_wb_valid;
  logic [31:0] ptr_wb_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  load_unit i_load_unit (.*);

  function automatic logic [7:0] mb(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd29 + 32'd91 + (a >> 4);
    return t[7:0];
  endfunction

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {mb(a), mb(a + 1), mb(a + 2), mb(a + 3)};
  endfunction

  // expected result from the requirement text, byte by byte from memory
  function automatic logic [63:0] ref_result(input int sz, input int fx, input int ln,
                                             input logic [31:0] ea, input logic [31:0] old);
    logic [7:0] b0, b1, b2, b3;
    logic [31:0] r;
    b0 = mb(ea); b1 = mb(ea + 1); b2 = mb(ea + 2); b3 = mb(ea + 3);
    if (sz == 3) return {b0, b1, b2, b3, mb(ea + 4), mb(ea + 5), mb(ea + 6), mb(ea + 7)};
    r = 32'h0;
    if (sz == 0) begin
      if (fx == 1) r = {{24{b0[7]}}, b0};
      else if (fx == 5) begin r = old; r[ln*8 +: 8] = b0; end
      else r = {24'h0, b0};
    end else if (sz == 1) begin
      if (fx == 1) r = {{16{b0[7]}}, b0, b1};
      else if (fx == 2) r = {{16{b1[7]}}, b1, b0};
      else if (fx == 3) r = {16'h0, b1, b0};
      else if (fx == 5) begin r = old; r[(ln % 2)*16 +: 16] = {b0, b1}; end
      else r = {16'h0, b0, b1};
    end else begin
      r = (fx == 4) ? {b3, b2, b1, b0} : {b0, b1, b2, b3};
    end
    return {32'h0, r};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input int mode, input int sz, input int fx,
                        input int ln, input int sh, input logic [31:0] base,
                        input logic [31:0] idx, input logic [15:0] disp,
                        input logic [31:0] old, input bit cond,
                        input logic [31:0] exp_ea, input bit exp_ptr_v,
                        input logic [31:0] exp_ptr, input int delay);
    logic [63:0] exp_res;
    @(negedge clk);
    op_valid = 1'b1; op_mode = 4'(mode); op_size = 2'(sz); op_fmt = 3'(fx);
    op_lane = 2'(ln); op_shamt = 2'(sh); op_base = base; op_index = idx;
    op_disp = disp; op_dest_old = old; op_cond_ok = cond;
    check(op_ready == 1'b1, {req, " ready before issue"}, 64'(op_ready), 64'd1);
    @(negedge clk);
    op_valid = 1'b0;
    if (mode == 6 && !cond) begin
      check(!mem_req_valid && !ptr_wb_valid && op_ready, {req, " skipped load quiet"},
            64'({mem_req_valid, ptr_wb_valid, op_ready}), 64'b001);
      @(negedge clk);
      check(!wb_valid && !mem_req_valid, {req, " skipped load no write"},
            64'({wb_valid, mem_req_valid}), 64'd0);
      return;
    end
    check(mem_req_valid && !op_ready, {req, " request raised"},
          64'({mem_req_valid, op_ready}), 64'b10);
    check(mem_req_addr == exp_ea, {req, " address"}, 64'(mem_req_addr), 64'(exp_ea));
    check(mem_req_size == 2'(sz), {req, " size"}, 64'(mem_req_size), 64'(sz));
    check(ptr_wb_valid == exp_ptr_v, {req, " pointer pulse"}, 64'(ptr_wb_valid), 64'(exp_ptr_v));
    if (exp_ptr_v)
      check(ptr_wb_data == exp_ptr, {req, " pointer value"}, 64'(ptr_wb_data), 64'(exp_ptr));
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == exp_ea && !ptr_wb_valid, {req, " R13 request held"},
            64'(mem_req_addr), 64'(exp_ea));
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(!mem_req_valid && !op_ready, {req, " R13 waiting"},
          64'({mem_req_valid, op_ready}), 64'd0);
    mem_rsp_valid = 1'b1;
    mem_rsp_data = (sz == 3) ? {mword(exp_ea), mword(exp_ea + 4)}
                             : {32'hDEADBEEF, mword({exp_ea[31:2], 2'b00})};
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    exp_res = ref_result(sz, fx, ln, exp_ea, old);
    check(wb_valid && op_ready, {req, " R13 result pulse"}, 64'({wb_valid, op_ready}), 64'b11);
    check(wb_data == exp_res, {req, " result"}, wb_data, exp_res);
    @(negedge clk);
    check(!wb_valid, {req, " R13 single pulse"}, 64'(wb_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(op_ready && !mem_req_valid && !wb_valid && !ptr_wb_valid, "R1 reset state",
          64'({op_ready, mem_req_valid, wb_valid, ptr_wb_valid}), 64'b1000);
    rst_n = 1'b1;
    // mode sz fmt lane sh base idx disp old cond ea ptrv ptr delay
    run_op("R2 R9 post-inc word",  0, 2, 0, 0, 0, 32'h100, 0, 0, 0, 1, 32'h100, 1, 32'h104, 0);
    run_op("R2 R9 pre-dec half sx", 1, 1, 1, 0, 0, 32'h200, 0, 0, 0, 1, 32'h1FE, 1, 32'h1FE, 2);
    run_op("R2 R12 post-inc dword", 0, 3, 0, 0, 0, 32'h300, 0, 0, 0, 1, 32'h300, 1, 32'h308, 1);
    run_op("R3 short half",        2, 1, 0, 0, 0, 32'h400, 0, 16'hFFFF, 0, 1, 32'h40E, 0, 0, 0);
    run_op("R3 short word",        2, 2, 0, 0, 0, 32'h500, 0, 16'hFFFF, 0, 1, 32'h57C, 0, 0, 3);
    run_op("R3 R9 short byte",     2, 0, 0, 0, 0, 32'h600, 0, 16'hFFFD, 0, 1, 32'h605, 0, 0, 0);
    run_op("R4 R9 long byte sx",   3, 0, 1, 0, 0, 32'h1000, 0, 16'hFFF9, 0, 1, 32'hFF9, 0, 0, 0);
    run_op("R4 long word",         3, 2, 0, 0, 0, 32'h0, 0, 16'h1234, 0, 1, 32'h1234, 0, 0, 0);
    run_op("R5 index shift",       4, 2, 0, 0, 3, 32'h800, 32'h21, 0, 0, 1, 32'h908, 0, 0, 0);
    run_op("R5 index byte",        5, 2, 0, 2, 0, 32'h900, 32'h11223344, 0, 0, 1, 32'h988, 0, 0, 1);
    run_op("R6 cond word",         6, 2, 0, 0, 0, 32'h2000, 0, 16'hFFFF, 0, 1, 32'h27FC, 0, 0, 0);
    run_op("R6 cond half sx",      6, 1, 1, 0, 0, 32'h10, 0, 16'h0003, 0, 1, 32'h16, 0, 0, 0);
    run_op("R6 cond false",        6, 2, 0, 0, 0, 32'h2000, 0, 16'h0004, 0, 0, 32'h0, 0, 0, 0);
    run_op("R7 aligned base",      7, 2, 0, 0, 0, 32'h3003, 0, 16'hFFFF, 0, 1, 32'h31FC, 0, 0, 0);
    run_op("R8 R10 swap half sx",  8, 1, 2, 0, 0, 32'h4000, 0, 16'h0FFF, 0, 1, 32'h3FFE, 0, 0, 0);
    run_op("R10 swap half zx",     8, 1, 3, 0, 0, 32'h4000, 0, 16'h0005, 0, 1, 32'h400A, 0, 0, 0);
    run_op("R8 R10 swap word",     8, 2, 4, 0, 0, 32'h8000, 0, 16'h0801, 0, 1, 32'h6004, 0, 0, 2);
    run_op("R11 insert byte",      8, 0, 5, 1, 0, 32'h5000, 0, 16'h0003, 32'hAABBCCDD, 1, 32'h5003, 0, 0, 0);
    run_op("R11 insert half",      8, 1, 5, 1, 0, 32'h5000, 0, 16'h0002, 32'h11223344, 1, 32'h5004, 0, 0, 0);
    run_op("R2 R12 pre-dec dword", 1, 3, 0, 0, 0, 32'h710, 0, 0, 0, 1, 32'h708, 1, 32'h708, 0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule